// File: doc/BRIEF.md
# Complementary Gate Command Qualifier

This block sits in the control path of a power-switch gate driver. It takes two command inputs of opposite polarity, one active high and one active low, and reduces them to a single registered gate-on request. A designer can steer the switch with the active-high input and tie the active-low input low, or tie the active-high input high and steer with the active-low input. Either way the drive is on only when the active-high input is high and the active-low input is low.

Each input is brought into the clock domain by a two-flop synchronizer. A glitch filter then accepts a new level only after the synchronized value has differed from the accepted level for `FILT_LEN` consecutive clocks. The combined request is also gated. It is blocked while the supply-ready flag is low and for `READY_DLY` clocks after that flag returns. It is also blocked for a mute window of `MUTE_LEN` clocks after a fault-mute request. All timings are parameters in clock cycles. The defaults assume a 50 MHz clock: a 2-cycle filter sits between the 10 ns reject limit and the 40 ns pass limit, a 3-cycle settle covers roughly 55 ns, and the mute window is 5 ms.

Top module: `gate_cmd_qualifier`

## Requirements
- R1: The registered output `drive_o` can be high only when the accepted active-high level is 1 and the accepted active-low level is 0. With both inputs held steady, the output equals `cmd_pos_i & ~cmd_neg_i`.
- R2: With `cmd_neg_i` held low, `drive_o` follows `cmd_pos_i` in the same polarity.
- R3: With `cmd_pos_i` held high, `drive_o` follows `cmd_neg_i` in the opposite polarity.
- R4: An input level held for fewer than `FILT_LEN` clock samples leaves `drive_o` unchanged. A level held for `FILT_LEN` samples or more is passed with its width preserved. The output responds `FILT_LEN + 3` rising edges after the first edge that samples the new level.
- R5: A glitch filter restarts its count whenever the synchronized level matches the accepted level again. Two sub-length pulses separated by a single-cycle gap therefore produce no output.
- R6: The first rising edge that samples `ready_i` low drives `drive_o` low.
- R7: After `ready_i` returns high, `drive_o` stays low for `READY_DLY` rising edges and may rise on the next one. The same settle delay applies after reset.
- R8: The edge that samples `fault_mute_i` high forces `drive_o` low, and the output stays low for the next `MUTE_LEN` edges. A new request inside the window restarts the window.
- R9: Synchronous active-high reset clears `drive_o`. It sets the accepted levels to the inactive pair: active-high input low, active-low input high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_pos_i | input | 1 | Active-high command |
| cmd_neg_i | input | 1 | Active-low command |
| ready_i | input | 1 | Supply-ready flag, high when the supply is good |
| fault_mute_i | input | 1 | Fault-mute request; starts the mute window |
| drive_o | output | 1 | Qualified gate-on request, registered |

## Verification
A command change takes two synchronizer edges, `FILT_LEN` filter samples and one output register edge to reach `drive_o`. The bench therefore expects the first high sample exactly `FILT_LEN + 3` edges after a pulse starts. It also counts high samples over the whole pulse to confirm the width is preserved or the pulse is rejected. Gating uses one edge for a ready drop, `READY_DLY + 1` edges for a ready return, and `MUTE_LEN + 1` edges after a fault. Every check is taken on a falling edge after exactly that many rising edges, so the sample lands on the first cycle where the result becomes valid, or on the last cycle before it.

// File: rtl/gq_pkg.sv
package gq_pkg;

    typedef struct packed {
        logic pos;
        logic neg;
    } cmd_pair_t;

    localparam cmd_pair_t CMD_IDLE = '{pos: 1'b0, neg: 1'b1};

    typedef enum logic [1:0] {
        GATE_LIVE      = 2'd0,
        GATE_NO_SUPPLY = 2'd1,
        GATE_SETTLING  = 2'd2,
        GATE_MUTED     = 2'd3
    } gate_why_e;

    function automatic logic cmd_on(input cmd_pair_t c);
        return c.pos & ~c.neg;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gq_sync.sv
module gq_sync #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gq_filter.sv
module gq_filter
    import gq_pkg::*;
#(
    parameter int unsigned FILT_LEN = 2,
    parameter bit          RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    localparam int unsigned CW = cnt_bits(FILT_LEN);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_o <= RST_VAL;
            run_cnt <= '0;
        end else if (raw_i == level_o) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            level_o <= raw_i;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R4: an accepted level always comes from the synchronized input
    a_r4_accept_source: assert property (@(posedge clk) disable iff (rst)
        (level_o != $past(level_o)) |-> (level_o == $past(raw_i)));

    // R5: agreement with the accepted level clears the run count
    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        (raw_i == level_o) |=> (run_cnt == '0));
endmodule

// File: rtl/gq_gate.sv
module gq_gate
    import gq_pkg::*;
#(
    parameter int unsigned READY_DLY = 3,
    parameter int unsigned MUTE_LEN  = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic ready_i,
    input  logic fault_i,
    output logic open_o
);
    localparam int unsigned RW = cnt_bits(READY_DLY);
    localparam int unsigned MW = $clog2(MUTE_LEN + 1);
    localparam logic [RW-1:0] SETTLE_LAST = RW'(READY_DLY - 1);
    localparam logic [MW-1:0] MUTE_LOAD   = MW'(MUTE_LEN);

    logic [RW-1:0] settle_cnt;
    logic          settled;
    logic [MW-1:0] mute_cnt;
    gate_why_e     why;

    always_ff @(posedge clk) begin
        if (rst || !ready_i) begin
            settle_cnt <= '0;
            settled    <= 1'b0;
        end else if (!settled) begin
            if (settle_cnt == SETTLE_LAST) begin
                settled <= 1'b1;
            end else begin
                settle_cnt <= settle_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mute_cnt <= '0;
        end else if (fault_i) begin
            mute_cnt <= MUTE_LOAD;
        end else if (mute_cnt != '0) begin
            mute_cnt <= mute_cnt - 1'b1;
        end
    end

    always_comb begin
        if (!ready_i) begin
            why = GATE_NO_SUPPLY;
        end else if (!settled) begin
            why = GATE_SETTLING;
        end else if (fault_i || (mute_cnt != '0)) begin
            why = GATE_MUTED;
        end else begin
            why = GATE_LIVE;
        end
    end

    assign open_o = (why == GATE_LIVE);

    // R6: a low ready flag drops the settle state on the next edge
    a_r6_settle_drop: assert property (@(posedge clk) disable iff (rst)
        !ready_i |=> !settled);

    // R7: settling only completes while ready was seen high
    a_r7_settle_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(settled) |-> $past(ready_i));

    // R8: a mute request opens a non-empty window
    a_r8_mute_load: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> (mute_cnt != '0));
endmodule

// File: rtl/gate_cmd_qualifier.sv
module gate_cmd_qualifier
    import gq_pkg::*;
#(
    parameter int unsigned FILT_LEN  = 2,
    parameter int unsigned READY_DLY = 3,
    parameter int unsigned MUTE_LEN  = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_pos_i,
    input  logic cmd_neg_i,
    input  logic ready_i,
    input  logic fault_mute_i,
    output logic drive_o
);
    localparam int unsigned NCH = 2;

    logic [NCH-1:0] pin_v;
    logic [NCH-1:0] sync_v;
    logic [NCH-1:0] acc_v;
    cmd_pair_t      acc_pair;
    logic           gate_open;

    assign pin_v = {cmd_neg_i, cmd_pos_i};

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        gq_sync #(
            .RST_VAL(i == 1)
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pin_v[i]),
            .q   (sync_v[i])
        );

        gq_filter #(
            .FILT_LEN(FILT_LEN),
            .RST_VAL (i == 1)
        ) u_filt (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (sync_v[i]),
            .level_o (acc_v[i])
        );
    end

    assign acc_pair = '{pos: acc_v[0], neg: acc_v[1]};

    gq_gate #(
        .READY_DLY(READY_DLY),
        .MUTE_LEN (MUTE_LEN)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .ready_i (ready_i),
        .fault_i (fault_mute_i),
        .open_o  (gate_open)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_o <= 1'b0;
        end else begin
            drive_o <= cmd_on(acc_pair) & gate_open;
        end
    end

    // R1: the output is on only after an active pair was accepted
    a_r1_polarity: assert property (@(posedge clk) disable iff (rst)
        drive_o |-> ($past(acc_v[0]) && !$past(acc_v[1])));

    // R6: a low ready flag forces the output off at the next edge
    a_r6_ready_off: assert property (@(posedge clk) disable iff (rst)
        !ready_i |=> !drive_o);

    // R8: a fault-mute request forces the output off at the next edge
    a_r8_fault_off: assert property (@(posedge clk) disable iff (rst)
        fault_mute_i |=> !drive_o);

    // R9: the accepted pair is inactive on the first cycle out of reset
    a_r9_reset_idle: assert property (@(posedge clk)
        $fell(rst) |-> (acc_pair == CMD_IDLE && !drive_o));
endmodule

// File: tb/tb_gate_cmd_qualifier.sv
module tb_gate_cmd_qualifier;
    localparam int FL = 4;
    localparam int RD = 3;
    localparam int ML = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pos = 1'b1;
    logic neg = 1'b0;
    logic rdy = 1'b1;
    logic flt = 1'b0;
    logic drive;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    gate_cmd_qualifier #(
        .FILT_LEN (FL),
        .READY_DLY(RD),
        .MUTE_LEN (ML)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .cmd_pos_i    (pos),
        .cmd_neg_i    (neg),
        .ready_i      (rdy),
        .fault_mute_i (flt),
        .drive_o      (drive)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Holds the controlling input active for p edges and measures the output pulse.
    task automatic pulse(input string req, input bit use_neg, input int p);
        int hi = 0;
        int first = 0;
        if (use_neg) neg = 1'b0; else pos = 1'b1;
        for (int k = 1; k <= p + FL + 12; k++) begin
            @(negedge clk);
            if (k == p) begin
                if (use_neg) neg = 1'b1; else pos = 1'b0;
            end
            if (drive) begin
                hi++;
                if (first == 0) first = k;
            end
        end
        chk(req, hi, (p >= FL) ? p : 0);
        if (p >= FL) chk(req, first, FL + 3);
    endtask

    initial begin
        step(3);
        chk("R9", drive, 0);
        rst = 1'b0;
        step(FL + 2);
        chk("R9", drive, 0);
        step(1);
        chk("R4", drive, 1);

        // R1: every steady pair
        for (int c = 0; c < 4; c++) begin
            pos = c[0];
            neg = c[1];
            step(20);
            chk("R1", drive, (c[0] && !c[1]) ? 1 : 0);
        end

        // R2 / R4: active-high pulse sweep with the active-low input low
        pos = 1'b0; neg = 1'b0;
        step(20);
        for (int p = 1; p <= 8; p++) begin
            pulse("R2", 1'b0, p);
            pulse("R4", 1'b0, p);
        end

        // R3: active-low pulse sweep with the active-high input high
        pos = 1'b1; neg = 1'b1;
        step(20);
        chk("R3", drive, 0);
        for (int p = 1; p <= 8; p++) pulse("R3", 1'b1, p);

        // R5: two short pulses with a one-cycle gap
        pos = 1'b0; neg = 1'b0;
        step(20);
        begin
            int hi = 0;
            for (int k = 1; k <= 30; k++) begin
                if (k == 1 || k == FL + 1) pos = 1'b1;
                if (k == FL || k == 2 * FL) pos = 1'b0;
                @(negedge clk);
                hi += int'(drive);
            end
            chk("R5", hi, 0);
        end

        // R6 / R7: supply-ready drop and return
        pos = 1'b1;
        step(20);
        chk("R6", drive, 1);
        rdy = 1'b0;
        step(1);
        chk("R6", drive, 0);
        step(5);
        rdy = 1'b1;
        step(RD);
        chk("R7", drive, 0);
        step(1);
        chk("R7", drive, 1);

        // R8: mute window length
        step(5);
        flt = 1'b1;
        step(1);
        flt = 1'b0;
        chk("R8", drive, 0);
        step(ML);
        chk("R8", drive, 0);
        step(1);
        chk("R8", drive, 1);

        // R8: a second request restarts the window
        flt = 1'b1;
        step(1);
        flt = 1'b0;
        step(10);
        flt = 1'b1;
        step(1);
        flt = 1'b0;
        step(ML);
        chk("R8", drive, 0);
        step(1);
        chk("R8", drive, 1);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule